// File: doc/BRIEF.md
# AND-OR Shared Bus Interconnect

This block ties a set of bus masters and a set of bus slaves onto one shared bus without any tri-state nets or wide multiplexers. Every master masks its request, write flag, address and write data with its own grant bit. The masked values of all masters are merged with a bitwise OR, so a master without the grant adds nothing to the bus. An address decoder built from per-slave base and mask parameters turns the merged address into a select for each slave. Each slave's read data and acknowledge are masked with that select and merged the same way. Write data and read data travel on separate paths.

Arbitration happens outside the block. It arrives as a grant vector that should hold at most one set bit. A transfer takes a single clock when the chosen slave acknowledges at once. A slave may also add wait cycles by holding its acknowledge low. There are no split transactions and no address pipelining. A request whose address hits no slave, or whose slave never answers, ends with an error pulse after a fixed number of cycles. A grant vector with more than one bit set raises a registered fault flag. All state runs on one clock with a synchronous active-high reset.

Top module: `andor_bus_fabric`

## Requirements
- R1: The shared address and write data (`s_addr`, `s_wdata`) equal the values of the one master whose grant bit is set. When no grant bit is set they are all zeros, whatever the ungranted masters drive.
- R2: While the granted master requests, `s_sel` has exactly one bit set: the lowest-numbered slave j for which `(s_addr & MASK_j) == BASE_j`. It is all zeros when nothing is requested or no slave matches. The default map is: slave 0 = 0x0000_0xxx, slave 1 = 0x0000_1xxx, slave 2 = 0x0000_2xxx, slave 3 = 0x8xxx_xxxx.
- R3: `m_rdata` equals the read data of the selected slave in the same cycle. It is zero when no slave is selected. The read data and acknowledge of slaves that are not selected have no effect.
- R4: `m_ack` is the selected slave's acknowledge, passed in the same cycle to the granted master only. Every other bit of `m_ack` stays low.
- R5: The block counts consecutive cycles in which a request is active and no acknowledge arrives. When the count reaches TIMEOUT (default 6), the granted master's `m_err` bit is high for that one cycle and the count restarts from zero. With a request held on an unmapped address, the first error therefore comes in the 7th cycle of the request.
- R6: A request acknowledged before the count reaches TIMEOUT raises no error, including one stretched by slave wait cycles.
- R7: `gnt_fault` is high in the cycle after any cycle in which two or more grant bits were set. It is low in the cycle after a grant with zero or one bits set.
- R8: After reset, `gnt_fault` is low and the timeout count is zero, so a new request on an unmapped address again waits the full TIMEOUT cycles.
- R9: `s_we` equals the write flag of the granted master, and is low when no master is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single bus clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | N_MST | Grant from the external arbiter, one bit per master |
| m_req | input | N_MST | Transfer request per master |
| m_we | input | N_MST | Write flag per master |
| m_addr | input | N_MST*32 | Address per master, master i at bits i*32 upward |
| m_wdata | input | N_MST*32 | Write data per master |
| m_rdata | output | 32 | Merged read data back to the masters |
| m_ack | output | N_MST | Transfer-complete strobe per master |
| m_err | output | N_MST | Timeout error strobe per master |
| s_sel | output | N_SLV | Decoded slave select |
| s_addr | output | 32 | Merged shared address |
| s_wdata | output | 32 | Merged shared write data |
| s_we | output | 1 | Merged write flag |
| s_rdata | input | N_SLV*32 | Read data per slave |
| s_ack | input | N_SLV | Acknowledge per slave |
| gnt_fault | output | 1 | Registered flag for a grant with more than one bit set |

## Verification
The merge paths have no state, so a wrong mask or a missing gate shows at the ports in the same cycle. The bench sets every ungranted master and every unselected slave to nonzero values, so any leak shows up as extra bits on the bus. A timeout counter that is off by one, or that does not clear on an acknowledge or on reset, moves the `m_err` pulse one or more cycles early or late. The bench's cycle-accurate model catches this on the first request to an unmapped address. A wrong grant-fault register shows one cycle after an illegal grant.

// File: rtl/andor_pkg.sv
package andor_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // true when more than one bit of v is set
  function automatic logic multi_hot(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction
endpackage

// File: rtl/andor_mgate.sv
module andor_mgate #(
  parameter int N_MST = 3,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_MST-1:0]    grant,
  input  logic [N_MST-1:0]    m_req,
  input  logic [N_MST-1:0]    m_we,
  input  logic [N_MST*AW-1:0] m_addr,
  input  logic [N_MST*DW-1:0] m_wdata,
  output logic                b_req,
  output logic                b_we,
  output logic [AW-1:0]       b_addr,
  output logic [DW-1:0]       b_wdata
);
  logic [AW-1:0] g_addr  [N_MST];
  logic [DW-1:0] g_wdata [N_MST];
  logic [N_MST-1:0] g_req, g_we;

  // each master is masked by its own grant bit
  for (genvar i = 0; i < N_MST; i++) begin : g_mask
    assign g_addr[i]  = m_addr[i*AW +: AW]  & {AW{grant[i]}};
    assign g_wdata[i] = m_wdata[i*DW +: DW] & {DW{grant[i]}};
    assign g_req[i]   = m_req[i] & grant[i];
    assign g_we[i]    = m_we[i]  & grant[i];
  end

  // wide OR merge
  always_comb begin
    b_addr  = '0;
    b_wdata = '0;
    for (int i = 0; i < N_MST; i++) begin
      b_addr  = b_addr  | g_addr[i];
      b_wdata = b_wdata | g_wdata[i];
    end
  end
  assign b_req = |g_req;
  assign b_we  = |g_we;

  // R1
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |-> (b_addr == '0 && b_wdata == '0 && !b_req));
  // R9
  idle_we_low_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |-> !b_we);
endmodule

// File: rtl/andor_decode.sv
module andor_decode #(
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*AW-1:0] SLV_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             b_req,
  input  logic [AW-1:0]    b_addr,
  output logic [N_SLV-1:0] sel
);
  logic [N_SLV-1:0] hit;

  for (genvar j = 0; j < N_SLV; j++) begin : g_match
    localparam logic [AW-1:0] BASE_J = SLV_BASE[j*AW +: AW];
    localparam logic [AW-1:0] MASK_J = SLV_MASK[j*AW +: AW];
    assign hit[j] = b_req && ((b_addr & MASK_J) == BASE_J);
  end

  // lowest index wins where windows overlap
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    for (int j = 0; j < N_SLV; j++) begin
      if (hit[j] && !taken) begin
        sel[j] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  // R2
  sel_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  // R2
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !b_req |-> (sel == '0));
endmodule

// File: rtl/andor_sgate.sv
module andor_sgate #(
  parameter int N_SLV = 4,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SLV-1:0]    sel,
  input  logic [N_SLV*DW-1:0] s_rdata,
  input  logic [N_SLV-1:0]    s_ack,
  output logic [DW-1:0]       rd_or,
  output logic                ack_or
);
  logic [DW-1:0] g_rd [N_SLV];

  for (genvar j = 0; j < N_SLV; j++) begin : g_mask
    assign g_rd[j] = s_rdata[j*DW +: DW] & {DW{sel[j]}};
  end

  always_comb begin
    rd_or = '0;
    for (int j = 0; j < N_SLV; j++) rd_or = rd_or | g_rd[j];
  end
  assign ack_or = |(s_ack & sel);

  // R3
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (rd_or == '0 && !ack_or));
endmodule

// File: rtl/andor_watch.sv
module andor_watch #(
  parameter int N_MST   = 3,
  parameter int TIMEOUT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] grant,
  input  logic             b_req,
  input  logic             ack_or,
  output logic             to_hit,
  output logic             gnt_fault
);
  import andor_pkg::*;
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] TO_V = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt;

  assign to_hit = b_req && (cnt == TO_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      gnt_fault <= 1'b0;
    end else begin
      if (to_hit)               cnt <= '0;
      else if (b_req && !ack_or) cnt <= cnt + 1'b1;
      else                       cnt <= '0;
      gnt_fault <= multi_hot(64'(grant));
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $past(b_req && !ack_or));
  // R5
  hit_restart_chk: assert property (@(posedge clk) disable iff (rst)
    to_hit |=> (cnt == '0));
  // R7
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(grant) > 1) |=> gnt_fault);
  // R7
  fault_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(grant) <= 1) |=> !gnt_fault);
endmodule

// File: rtl/andor_bus_fabric.sv
module andor_bus_fabric
  import andor_pkg::*;
#(
  parameter int N_MST   = 3,
  parameter int N_SLV   = 4,
  parameter int TIMEOUT = 6,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_BASE =
    {32'h8000_0000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [N_SLV*ADDR_W-1:0] SLV_MASK =
    {32'hF000_0000, 32'hFFFF_F000, 32'hFFFF_F000, 32'hFFFF_F000}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MST-1:0]        grant,
  input  logic [N_MST-1:0]        m_req,
  input  logic [N_MST-1:0]        m_we,
  input  logic [N_MST*ADDR_W-1:0] m_addr,
  input  logic [N_MST*DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0]       m_rdata,
  output logic [N_MST-1:0]        m_ack,
  output logic [N_MST-1:0]        m_err,
  output logic [N_SLV-1:0]        s_sel,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [DATA_W-1:0]       s_wdata,
  output logic                    s_we,
  input  logic [N_SLV*DATA_W-1:0] s_rdata,
  input  logic [N_SLV-1:0]        s_ack,
  output logic                    gnt_fault
);
  logic b_req, ack_or, to_hit;

  andor_mgate #(.N_MST(N_MST), .AW(ADDR_W), .DW(DATA_W)) u_mgate (
    .clk(clk), .rst(rst), .grant(grant), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata),
    .b_req(b_req), .b_we(s_we), .b_addr(s_addr), .b_wdata(s_wdata));

  andor_decode #(.N_SLV(N_SLV), .AW(ADDR_W),
                 .SLV_BASE(SLV_BASE), .SLV_MASK(SLV_MASK)) u_dec (
    .clk(clk), .rst(rst), .b_req(b_req), .b_addr(s_addr), .sel(s_sel));

  andor_sgate #(.N_SLV(N_SLV), .DW(DATA_W)) u_sgate (
    .clk(clk), .rst(rst), .sel(s_sel), .s_rdata(s_rdata), .s_ack(s_ack),
    .rd_or(m_rdata), .ack_or(ack_or));

  andor_watch #(.N_MST(N_MST), .TIMEOUT(TIMEOUT)) u_watch (
    .clk(clk), .rst(rst), .grant(grant), .b_req(b_req), .ack_or(ack_or),
    .to_hit(to_hit), .gnt_fault(gnt_fault));

  // completion strobes routed back to the granted master only
  assign m_ack = grant & {N_MST{ack_or}};
  assign m_err = grant & {N_MST{to_hit}};

  // R4
  ack_to_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_fault == 1'b0 && $onehot0(grant)) |-> ((m_ack & ~grant) == '0));
  // R5
  err_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (s_sel == '0) |-> (m_ack == '0));
endmodule

// File: tb/andor_bus_fabric_test.sv
module andor_bus_fabric_test;
  localparam int NM = 3;
  localparam int NS = 4;
  localparam int TO = 6;

  logic clk = 0, rst = 1;
  logic [NM-1:0] grant = '0, m_req = '0, m_we = '0;
  logic [NM*32-1:0] m_addr = '0, m_wdata = '0;
  logic [31:0] m_rdata, s_addr, s_wdata;
  logic [NM-1:0] m_ack, m_err;
  logic [NS-1:0] s_sel, s_ack = '0;
  logic s_we, gnt_fault;
  logic [NS*32-1:0] s_rdata = '0;

  andor_bus_fabric uut (
    .clk(clk), .rst(rst), .grant(grant), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .m_err(m_err), .s_sel(s_sel), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_we(s_we), .s_rdata(s_rdata), .s_ack(s_ack), .gnt_fault(gnt_fault));

  always #5 clk = ~clk;

  typedef struct {
    string tag;
    logic [31:0] addr, wdata, rdata;
    logic we, fault, chk_bus;
    logic [NS-1:0] sel;
    logic [NM-1:0] ack, err;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  int cnt_m = 0;
  logic multi_m = 0;
  logic [31:0] ma [NM];
  logic [31:0] mw [NM];
  logic [31:0] srd [NS];
  logic [NM-1:0] mreq_v = '0, mwe_v = '0;
  logic [NS-1:0] sack_v = '0;

  function automatic void chk(string tag, string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, tag, act, exp);
    end
  endfunction

  // slave map from R2
  function automatic int decode(logic [31:0] a);
    if ((a & 32'hFFFF_F000) == 32'h0000_0000) return 0;
    if ((a & 32'hFFFF_F000) == 32'h0000_1000) return 1;
    if ((a & 32'hFFFF_F000) == 32'h0000_2000) return 2;
    if ((a & 32'hF000_0000) == 32'h8000_0000) return 3;
    return -1;
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input logic [NM-1:0] g, input string tag);
    exp_t e;
    int gi, js, ones;
    logic breq, ackor, hit;
    @(negedge clk);
    rst = 0;
    grant = g;
    for (int i = 0; i < NM; i++) begin
      m_addr[i*32 +: 32]  = ma[i];
      m_wdata[i*32 +: 32] = mw[i];
    end
    for (int j = 0; j < NS; j++) s_rdata[j*32 +: 32] = srd[j];
    m_req = mreq_v; m_we = mwe_v; s_ack = sack_v;
    ones = $countones(g);
    gi = -1;
    for (int i = 0; i < NM; i++) if (g[i]) gi = i;
    e.tag = tag;
    e.chk_bus = (ones <= 1);
    breq = (ones == 1) ? mreq_v[gi] : 1'b0;
    e.addr  = (ones == 1) ? ma[gi] : 32'h0;
    e.wdata = (ones == 1) ? mw[gi] : 32'h0;
    e.we    = (ones == 1) ? mwe_v[gi] : 1'b0;
    js = breq ? decode(e.addr) : -1;
    e.sel = '0;
    if (js >= 0) e.sel[js] = 1'b1;
    e.rdata = (js >= 0) ? srd[js] : 32'h0;
    ackor = (js >= 0) ? sack_v[js] : 1'b0;
    e.ack = ackor ? g : '0;
    hit = breq && (cnt_m == TO);
    e.err = hit ? g : '0;
    e.fault = multi_m;
    cnt_m = hit ? 0 : ((breq && !ackor) ? cnt_m + 1 : 0);
    multi_m = (ones > 1);
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    cnt_m = 0;
    multi_m = 0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.chk_bus) begin
          chk(e.tag, "R1", s_addr, e.addr);
          chk(e.tag, "R1", s_wdata, e.wdata);
          chk(e.tag, "R9", 32'(s_we), 32'(e.we));
        end
        chk(e.tag, "R2", 32'(s_sel), 32'(e.sel));
        chk(e.tag, "R3", m_rdata, e.rdata);
        chk(e.tag, "R4", 32'(m_ack), 32'(e.ack));
        chk(e.tag, "R5 R6", 32'(m_err), 32'(e.err));
        chk(e.tag, "R7", 32'(gnt_fault), 32'(e.fault));
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) begin
      ma[i] = 32'h0000_3000 + 32'(i);
      mw[i] = 32'h5A5A_0000 + 32'(i);
    end
    for (int j = 0; j < NS; j++) srd[j] = 32'hC0DE_0000 | (32'(j) << 8) | 32'h11;
    repeat (3) @(negedge clk);
    // R8: first cycle out of reset
    step(3'b000, "R8 after reset idle");

    // garbage on every unselected slave, all slaves ack
    sack_v = '1;
    mreq_v = 3'b111;
    mwe_v  = 3'b111;
    ma[0] = 32'h0000_1004; mw[0] = 32'hDEAD_0001; mwe_v[0] = 1'b1;
    ma[1] = 32'h0000_0010; mw[1] = 32'hBEEF_0002; mwe_v[1] = 1'b0;
    ma[2] = 32'h8000_0040; mw[2] = 32'hFACE_0003; mwe_v[2] = 1'b1;
    step(3'b001, "R1 master0 write slave1");
    step(3'b010, "R3 master1 read slave0");
    step(3'b100, "R4 master2 to slave3");
    // R1: no grant while all masters drive
    step(3'b000, "R1 no grant all zero");

    // R6: slave2 wait states then ack
    ma[0] = 32'h0000_2008;
    sack_v[2] = 1'b0;
    step(3'b001, "R6 wait 1");
    step(3'b001, "R6 wait 2");
    sack_v[2] = 1'b1;
    step(3'b001, "R6 ack after waits");

    // R5: unmapped address held past the limit
    ma[1] = 32'h0000_5000;
    for (int k = 0; k < TO + 3; k++) step(3'b010, "R5 unmapped timeout");

    // R8: reset in the middle of a count
    for (int k = 0; k < 3; k++) step(3'b010, "R8 partial count");
    do_reset();
    for (int k = 0; k < TO + 2; k++) step(3'b010, "R8 count restart");

    // R7: illegal grants with no requests
    mreq_v = '0;
    step(3'b011, "R7 two grants");
    step(3'b000, "R7 fault seen");
    step(3'b110, "R7 two grants again");
    step(3'b111, "R7 three grants");
    step(3'b100, "R7 legal after illegal");
    step(3'b100, "R7 fault cleared");

    // R2: request with no grant selects nothing
    mreq_v = 3'b111;
    ma[2] = 32'h8123_4560;
    srd[3] = 32'h0BAD_F00D;
    step(3'b100, "R2 slave3 wide window");
    step(3'b000, "R2 no grant no select");
    mreq_v = '0;
    step(3'b000, "R2 idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule